// File: doc/BRIEF.md
# Processor Status Flags Register

This block is the 32-bit application status word of a small processor core. It keeps the four condition flags (negative, zero, carry, overflow), a sticky saturation flag and four per-lane greater-or-equal flags written by the SIMD unit. The block derives the condition flags itself from the operands of a flag-setting operation: add, subtract/compare, compare-negative and test-equivalence. It also accepts a saturation-overflow pulse and a lane-flag strobe.

Software reaches the register through a read port (status to general register) and a write port (general register to status). A privilege input selects how much of the word is visible and writable. Privileged code sees and writes all 32 bits. User code sees only the flag bits, with every other bit reading as zero, and its writes to those other bits are dropped. All updates take effect at a clock edge and appear on the read port in the following cycle.

Top module: `psr_status_reg`

## Requirements
- R1: After reset every bit of the status word is zero, as read in privileged mode.
- R2: The flags sit at these bits: N at 31, Z at 30, C at 29, V at 28, Q at 27 and lane flags at 19:16. With `priv`=0, every other bit of `rd_data` reads as zero. With `priv`=1, all 32 stored bits are read.
- R3: For `alu_op`=1 (add) and `alu_op`=3 (compare-negative), the sum is a+b. N is sum bit 31 and Z is (sum==0). C is the unsigned carry out. V is set when both operands have the same sign and the sum's sign differs. A sum with b=0 therefore gives C=0.
- R4: For `alu_op`=2 (subtract/compare), the result is a-b. N and Z follow the result. C=1 means no borrow (a>=b unsigned). V is set when the operand signs differ and the result's sign differs from a. Comparing a value with itself gives N=0, Z=1, C=1, V=0.
- R5: For `alu_op`=4 (test-equivalence), N and Z come from a XOR b, and C and V keep their previous values.
- R6: The lane flags load `simd_ge` only when `simd_ge_we` is 1. Arithmetic operations never change them.
- R7: A `sat_ovf` pulse sets Q. Q then stays set through any later flag updates, and only a register write clears it.
- R8: A write with `priv`=0 changes only bits 31:27 and 19:16. The other stored bits keep their values, as seen by a later privileged read.
- R9: A write with `priv`=1 loads all 32 bits of `wr_data`.
- R10: When `wr_en` is 1, the written value wins over any flag update, lane-flag load or saturation pulse in the same cycle.
- R11: `alu_op` values 0, 5, 6 and 7 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 3 | Flag operation: 0 none, 1 add, 2 subtract, 3 compare-negative, 4 test-equivalence |
| alu_a | input | 32 | First operand |
| alu_b | input | 32 | Second operand |
| simd_ge_we | input | 1 | Load strobe for the lane flags |
| simd_ge | input | 4 | Lane greater-or-equal results |
| sat_ovf | input | 1 | Saturating-operation overflow pulse |
| wr_en | input | 1 | Register write from a general register |
| wr_data | input | 32 | Value to write |
| priv | input | 1 | 1 = privileged access, 0 = user access |
| rd_data | output | 32 | Status word as visible at the current privilege |

## Verification
The bench targets six corner cases:
- A compare of a value with itself must report carry set. A design that treated carry on subtraction as a borrow would report it clear.
- An add or compare-negative against zero must leave carry clear.
- Test-equivalence must keep the previous carry and overflow. A design that cleared them would lose state that was loaded deliberately just before.
- The saturation flag must survive many later arithmetic updates and clear only on a write. A design that let the flags update overwrite Q, or a write that skipped bit 27, would show up here.
- User-mode writes of all ones must leave the reserved bits untouched when read back in privileged mode.
- When a write and every kind of flag update arrive in the same cycle, the written value must win.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W    = 32;
  localparam int BIT_N    = 31;
  localparam int BIT_Z    = 30;
  localparam int BIT_C    = 29;
  localparam int BIT_V    = 28;
  localparam int BIT_Q    = 27;
  localparam int GE_LO    = 16;
  localparam int GE_W     = 4;
  localparam int GE_HI    = GE_LO + GE_W - 1;
  localparam logic [PSR_W-1:0] USER_MASK = 32'hF80F_0000;

  typedef enum logic [2:0] {
    FOP_NONE = 3'd0,
    FOP_ADD  = 3'd1,
    FOP_SUB  = 3'd2,
    FOP_CMN  = 3'd3,
    FOP_TEQ  = 3'd4
  } fop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/psr_flag_gen.sv
module psr_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output psr_pkg::nzcv_t    flags,
  output logic              upd_nz,
  output logic              upd_cv
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] res;
  logic              is_sub;

  always_comb begin
    is_sub = (op == psr_pkg::FOP_SUB);
    b_eff  = is_sub ? ~b : b;
    cin    = is_sub;
    sum    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    res    = (op == psr_pkg::FOP_TEQ) ? (a ^ b) : sum[DATA_W-1:0];
  end

  always_comb begin
    flags.n = res[MSB];
    flags.z = (res == '0);
    flags.c = sum[DATA_W];
    if (is_sub)
      flags.v = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
    else
      flags.v = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
    case (op)
      psr_pkg::FOP_ADD,
      psr_pkg::FOP_SUB,
      psr_pkg::FOP_CMN: begin upd_nz = 1'b1; upd_cv = 1'b1; end
      psr_pkg::FOP_TEQ: begin upd_nz = 1'b1; upd_cv = 1'b0; end
      default:          begin upd_nz = 1'b0; upd_cv = 1'b0; end
    endcase
  end
endmodule

// File: rtl/psr_priv_mask.sv
module psr_priv_mask #(
  parameter int W = 32,
  parameter logic [W-1:0] USER_BITS = '1
) (
  input  logic         priv,
  output logic [W-1:0] wr_mask,
  output logic [W-1:0] rd_mask
);
  always_comb begin
    wr_mask = priv ? {W{1'b1}} : USER_BITS;
    rd_mask = wr_mask;
  end
endmodule

// File: rtl/psr_core.sv
module psr_core (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [psr_pkg::PSR_W-1:0]    wr_data,
  input  logic [psr_pkg::PSR_W-1:0]    wr_mask,
  input  psr_pkg::nzcv_t               flags,
  input  logic                         upd_nz,
  input  logic                         upd_cv,
  input  logic                         ge_we,
  input  logic [psr_pkg::GE_W-1:0]     ge,
  input  logic                         sat_ovf,
  output logic [psr_pkg::PSR_W-1:0]    psr_q
);
  import psr_pkg::*;

  logic [PSR_W-1:0] psr_d;
  logic             psr_en;

  always_comb begin
    psr_d  = psr_q;
    psr_en = wr_en | upd_nz | upd_cv | ge_we | sat_ovf;
    if (wr_en) begin
      psr_d = (psr_q & ~wr_mask) | (wr_data & wr_mask);
    end else begin
      if (upd_nz) begin
        psr_d[BIT_N] = flags.n;
        psr_d[BIT_Z] = flags.z;
      end
      if (upd_cv) begin
        psr_d[BIT_C] = flags.c;
        psr_d[BIT_V] = flags.v;
      end
      if (ge_we)   psr_d[GE_HI:GE_LO] = ge;
      if (sat_ovf) psr_d[BIT_Q]       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psr_q <= '0;
    else if (psr_en) psr_q <= psr_d;
  end
endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  alu_op,
  input  logic [31:0] alu_a,
  input  logic [31:0] alu_b,
  input  logic        simd_ge_we,
  input  logic [3:0]  simd_ge,
  input  logic        sat_ovf,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        priv,
  output logic [31:0] rd_data
);
  import psr_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  nzcv_t            flags;
  logic             upd_nz;
  logic             upd_cv;
  logic [PSR_W-1:0] wr_mask;
  logic [PSR_W-1:0] rd_mask;
  logic [PSR_W-1:0] psr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  psr_flag_gen #(.DATA_W(PSR_W)) u_flag_gen (
    .op     (alu_op),
    .a      (alu_a),
    .b      (alu_b),
    .flags  (flags),
    .upd_nz (upd_nz),
    .upd_cv (upd_cv)
  );

  psr_priv_mask #(.W(PSR_W), .USER_BITS(USER_MASK)) u_priv_mask (
    .priv    (priv),
    .wr_mask (wr_mask),
    .rd_mask (rd_mask)
  );

  psr_core u_core (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .flags   (flags),
    .upd_nz  (upd_nz),
    .upd_cv  (upd_cv),
    .ge_we   (simd_ge_we),
    .ge      (simd_ge),
    .sat_ovf (sat_ovf),
    .psr_q   (psr_q)
  );

  assign rd_data = psr_q & rd_mask;
endmodule

// File: rtl/psr_status_reg_chk.sv
module psr_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  alu_op,
  input logic [31:0] alu_a,
  input logic [31:0] alu_b,
  input logic        simd_ge_we,
  input logic [3:0]  simd_ge,
  input logic        sat_ovf,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        priv,
  input logic [31:0] rd_data
);
  a_r2_user_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> ((rd_data & ~32'hF80F_0000) == 32'h0));

  a_r7_sat_sets_q: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_ovf && !wr_en) |=> rd_data[27]);

  a_r7_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[27] && !wr_en) |=> rd_data[27]);

  a_r9_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv) |=> (!priv || rd_data == $past(wr_data)));

  a_r5_teq_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd4 && !wr_en) |=> (rd_data[29:28] == $past(rd_data[29:28])));

  a_r4_cmp_self: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd2 && alu_a == alu_b && !wr_en) |=> (rd_data[31:28] == 4'b0110));

  a_r6_ge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!simd_ge_we && !wr_en) |=> (rd_data[19:16] == $past(rd_data[19:16])));

  a_r6_ge_load: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_ge_we && !wr_en) |=> (rd_data[19:16] == $past(simd_ge)));
endmodule

bind psr_status_reg psr_status_reg_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_op     (alu_op),
  .alu_a      (alu_a),
  .alu_b      (alu_b),
  .simd_ge_we (simd_ge_we),
  .simd_ge    (simd_ge),
  .sat_ovf    (sat_ovf),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .priv       (priv),
  .rd_data    (rd_data)
);

// File: tb/test_psr_status_reg.sv
`timescale 1ns/1ps
module test_psr_status_reg;
  localparam logic [31:0] UMASK = 32'hF80F_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  alu_op;
  logic [31:0] alu_a, alu_b;
  logic        simd_ge_we;
  logic [3:0]  simd_ge;
  logic        sat_ovf;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        priv;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_psr;

  always #4 clk = ~clk;

  psr_status_reg i_psr_status_reg (
    .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .simd_ge_we(simd_ge_we), .simd_ge(simd_ge), .sat_ovf(sat_ovf),
    .wr_en(wr_en), .wr_data(wr_data), .priv(priv), .rd_data(rd_data)
  );

  function automatic logic [31:0] model(input logic [31:0] old, input logic [2:0] op,
      input logic [31:0] a, input logic [31:0] b, input logic gwe, input logic [3:0] g,
      input logic s, input logic w, input logic [31:0] wd, input logic p);
    logic [31:0] r, m, x;
    logic [32:0] u, sv;
    r = old;
    if (w) begin
      m = p ? 32'hFFFF_FFFF : UMASK;
      return (old & ~m) | (wd & m);
    end
    case (op)
      3'd1, 3'd3: begin
        u  = {1'b0, a} + {1'b0, b};
        sv = {a[31], a} + {b[31], b};
        r[31] = u[31]; r[30] = (u[31:0] == 0); r[29] = u[32]; r[28] = sv[32] ^ sv[31];
      end
      3'd2: begin
        x  = a - b;
        sv = {a[31], a} - {b[31], b};
        r[31] = x[31]; r[30] = (a == b); r[29] = (a >= b); r[28] = sv[32] ^ sv[31];
      end
      3'd4: begin
        x = a ^ b;
        r[31] = x[31]; r[30] = (x == 0);
      end
      default: ;
    endcase
    if (gwe) r[19:16] = g;
    if (s)   r[27]    = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic gwe, input logic [3:0] g, input logic s,
      input logic w, input logic [31:0] wd, input logic p);
    alu_op = op; alu_a = a; alu_b = b; simd_ge_we = gwe; simd_ge = g;
    sat_ovf = s; wr_en = w; wr_data = wd; priv = p;
    @(posedge clk);
    exp_psr = model(exp_psr, op, a, b, gwe, g, s, w, wd, p);
    @(negedge clk);
    alu_op = 3'd0; simd_ge_we = 1'b0; sat_ovf = 1'b0; wr_en = 1'b0;
    #1;
    check(tag, rd_data, exp_psr & (p ? 32'hFFFF_FFFF : UMASK));
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(200000 * 8);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; alu_op = 0; alu_a = 0; alu_b = 0; simd_ge_we = 0; simd_ge = 0;
    sat_ovf = 0; wr_en = 0; wr_data = 0; priv = 1'b1; exp_psr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset", rd_data, 32'h0);

    // R4 compare self: N=0 Z=1 C=1 V=0
    cyc("R4 cmp self", 3'd2, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 0, 0, 1);
    check("R4 cmp self const", rd_data, 32'h6000_0000);
    // R3 add zero clears carry, N from result
    cyc("R3 add zero", 3'd1, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0, 1);
    check("R3 add zero const", rd_data, 32'h8000_0000);
    // R3 carry and overflow on add
    cyc("R3 add ovf", 3'd1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0, 1);
    check("R3 add ovf const", rd_data, 32'h7000_0000);
    // R3 compare-negative against zero
    cyc("R3 cmn zero", 3'd3, 32'h0000_0005, 32'h0, 0, 0, 0, 0, 0, 1);
    check("R3 cmn zero const", rd_data, 32'h0000_0000);
    // R4 borrow-free with overflow, then R5 teq keeps C,V
    cyc("R4 sub ovf", 3'd2, 32'h8000_0000, 32'h1, 0, 0, 0, 0, 0, 1);
    check("R4 sub ovf const", rd_data, 32'h3000_0000);
    cyc("R5 teq", 3'd4, 32'hABCD_0000, 32'hABCD_0000, 0, 0, 0, 0, 0, 1);
    check("R5 teq const", rd_data, 32'h7000_0000);
    cyc("R5 teq neg", 3'd4, 32'h8000_0000, 32'h0, 0, 0, 0, 0, 0, 1);
    check("R5 teq neg const", rd_data, 32'hB000_0000);
    // R6 lane flags
    cyc("R6 ge load", 3'd0, 0, 0, 1, 4'hA, 0, 0, 0, 1);
    cyc("R6 ge kept by add", 3'd1, 32'h1, 32'h2, 0, 4'h5, 0, 0, 0, 1);
    check("R6 ge const", rd_data[19:16], 4'hA);
    // R7 sticky Q
    cyc("R7 sat set", 3'd0, 0, 0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++)
      cyc("R7 q sticky", 3'd2, $urandom, $urandom, 0, 0, 0, 0, 0, 0);
    check("R7 q still set", {31'h0, rd_data[27]}, 32'h1);
    cyc("R7 write clears q", 3'd0, 0, 0, 0, 0, 0, 1, 32'h0, 0);
    check("R7 q cleared", {31'h0, rd_data[27]}, 32'h0);
    // R8 user write all ones, privileged readback
    cyc("R8 user write", 3'd0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0);
    cyc("R8 priv readback", 3'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R8 reserved untouched", rd_data, 32'hF80F_0000);
    // R9 privileged write, R2 user view
    cyc("R9 priv write", 3'd0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, 1);
    check("R9 priv write const", rd_data, 32'h1234_5678);
    cyc("R2 user view", 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 user view const", rd_data, 32'h1004_0000);
    // R10 write priority over everything
    cyc("R10 priority", 3'd2, 32'h5, 32'h5, 1, 4'hF, 1, 1, 32'h0000_0000, 1);
    check("R10 priority const", rd_data, 32'h0);
    // R11 unused op codes
    cyc("R11 setup", 3'd2, 32'h0, 32'h1, 0, 0, 0, 0, 0, 1);
    for (int op = 5; op < 8; op++)
      cyc("R11 no update", op[2:0], 32'h0, 32'h0, 0, 0, 0, 0, 0, 1);
    check("R11 const", rd_data, 32'h8000_0000);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic w;
      string tag;
      op = 3'($urandom % 8);
      w  = ($urandom % 10) == 0;
      case (op)
        3'd1, 3'd3: tag = "R3 random";
        3'd2:       tag = "R4 random";
        3'd4:       tag = "R5 random";
        default:    tag = "R11 random";
      endcase
      if (w) tag = "R10 random";
      cyc(tag, op, pick_operand(), pick_operand(), ($urandom % 4) == 0,
          4'($urandom), ($urandom % 8) == 0, w, $urandom, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule